// File: doc/BRIEF.md
# SD SPI-Mode Command Engine

This block runs a single SD/MMC command on a card attached in SPI mode and returns the card's answer. A host pulses `start` with a 6-bit opcode, a 32-bit argument and a response kind. The engine then drives a byte-exchange port toward an external SPI shifter. First it sends one idle byte. Next it sends a six-byte command frame whose last byte carries a CRC7. It then clocks out all-ones filler while it looks for the status byte and collects whatever follows it.

The response kind sets how much follows the status byte: nothing, one extra status byte, a 32-bit big-endian word, or a busy phase. In the busy phase the card holds the line low until it finishes. When the command ends, `done` pulses for one cycle. At that point the status byte, the extra byte, the word and a 2-bit error class are all valid. Chip-select, card bring-up and data-block transfer are handled elsewhere.

Top module: `sd_cmd_engine`

## Requirements
- R1: After `start` is accepted, the first exchanged byte is 0xFF, and the second is 0x40 OR the opcode.
- R2: The next four exchanged bytes are the argument, most significant byte first. The seventh byte is {crc7, 1'b1}. The crc7 uses the polynomial x^7+x^3+1, starts from zero and runs MSB-first over the five bytes of frame that precede it (opcode 0 with argument 0 ends in 0x95; opcode 8 with argument 0x1AA ends in 0x87).
- R3: Every byte exchanged after the seven frame bytes is transmitted as 0xFF.
- R4: The status byte is the first received byte after the frame that is not 0xFF. Up to NCR_MAX+1 bytes are read to find it. If all of them are 0xFF, the command ends with error code 3 (timeout).
- R5: A status byte with bit 7 set ends the command at once with error code 1, and no further bytes are exchanged.
- R6: The status bits are parameter (bit 6), address (bit 5), erase-sequence (bit 4), command-CRC (bit 3), illegal-command (bit 2), erase-reset (bit 1) and idle (bit 0). Bits 6, 5 or 2 give code 1. Otherwise bit 3 gives code 2. Otherwise bits 4 or 1 give code 2. Idle alone gives code 0.
- R7: Response kind 2 (R2/R5) reads one further byte into `status_hi`.
- R8: Response kind 3 (R3/R4/R7) reads four further bytes into `resp_word`, the first received byte being the most significant.
- R9: Response kind 1 (R1B) keeps reading after the status byte until a nonzero byte arrives. If BUSY_MS milliseconds of clock cycles (at CLK_HZ) pass first, the command ends with error code 3.
- R10: `done` is high for exactly one cycle per command. `busy` rises in the cycle after `start` is taken and falls as `done` rises.
- R11: During and after reset, `done`, `busy` and `xfer_req` are low and `err_code` is 0. Response kind 0 (R1) ends right after the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (taken when idle) |
| opcode | input | 6 | Command index |
| argument | input | 32 | Command argument |
| resp_kind | input | 2 | 0 R1, 1 R1B, 2 R2/R5, 3 R3/R4/R7 |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 none, 1 invalid, 2 CRC/IO, 3 timeout |
| status_lo | output | 8 | Status byte |
| status_hi | output | 8 | Extra status byte (R2/R5) |
| resp_word | output | 32 | Four-byte response word (R3/R4/R7) |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_tx | output | 8 | Byte to transmit |
| xfer_ack | input | 1 | Exchange complete this cycle |
| xfer_rx | input | 8 | Byte received in the completed exchange |

## Verification
The bench builds the engine with CLK_HZ = 100000 and BUSY_MS = 10, which gives a busy window of 1000 cycles. This brings the R1B timeout within a short run, while NCR_MAX stays at its default of 8, so the full filler window is exercised. The shifter model answers with a latency that varies between exchanges. This shows that the engine follows the handshake and does not rely on fixed timing.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  typedef enum logic [1:0] {
    RK_R1  = 2'd0,
    RK_R1B = 2'd1,
    RK_R2  = 2'd2,
    RK_R3  = 2'd3
  } rkind_t;

  typedef enum logic [1:0] {
    EC_NONE    = 2'd0,
    EC_INVAL   = 2'd1,
    EC_CRCIO   = 2'd2,
    EC_TIMEOUT = 2'd3
  } ecode_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SEND,
    S_HUNT,
    S_MORE,
    S_BUSY
  } st_t;

  localparam int FRAME_BYTES = 7;
endpackage

// File: rtl/sdc_crc7.sv
module sdc_crc7 #(
  parameter int NBYTES = 5
) (
  input  logic [NBYTES*8-1:0] msg,
  output logic [6:0]          crc
);
  localparam int NBITS = NBYTES * 8;

  always_comb begin
    logic [6:0] r;
    logic       fb;
    r = 7'd0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      fb = r[6] ^ msg[i];
      r  = {r[5:0], 1'b0} ^ ({7{fb}} & 7'h09);
    end
    crc = r;
  end
endmodule

// File: rtl/sdc_r1_class.sv
module sdc_r1_class
  import sdc_pkg::*;
(
  input  logic [7:0] st,
  output ecode_t     cls
);
  always_comb begin
    if (st[6] | st[5] | st[2])
      cls = EC_INVAL;
    else if (st[3])
      cls = EC_CRCIO;
    else if (st[4] | st[1])
      cls = EC_CRCIO;
    else
      cls = EC_NONE;
  end
endmodule

// File: rtl/sdc_busy_timer.sv
module sdc_busy_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (cnt != CW'(LIMIT))
      cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));

  // R9: the engine must leave the busy phase once the window is spent
  p_window_r9: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < CW'(LIMIT)));
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sdc_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int BUSY_MS = 3000,
  parameter int NCR_MAX = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [5:0]  opcode,
  input  logic [31:0] argument,
  input  logic [1:0]  resp_kind,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err_code,
  output logic [7:0]  status_lo,
  output logic [7:0]  status_hi,
  output logic [31:0] resp_word,
  output logic        xfer_req,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_ack,
  input  logic [7:0]  xfer_rx
);
  localparam int BUSY_CYC = (CLK_HZ / 1000) * BUSY_MS;
  localparam int HW       = $clog2(NCR_MAX + 2);

  st_t          state;
  logic [2:0]   idx;
  logic [HW-1:0] hunt_n;
  logic [2:0]   more_n;
  logic [5:0]   op_q;
  logic [31:0]  arg_q;
  rkind_t       kind_q;
  ecode_t       cls_q;
  ecode_t       cls_now;
  logic [6:0]   crc_v;
  logic [7:0]   frame_byte;
  logic         tmr_exp;
  logic         hs;

  sdc_crc7 #(.NBYTES(5)) u_crc (
    .msg ({2'b01, op_q, arg_q}),
    .crc (crc_v)
  );

  sdc_r1_class u_cls (
    .st  (xfer_rx),
    .cls (cls_now)
  );

  sdc_busy_timer #(.LIMIT(BUSY_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (state == S_BUSY),
    .expired (tmr_exp)
  );

  always_comb begin
    case (idx)
      3'd0:    frame_byte = 8'hFF;
      3'd1:    frame_byte = {2'b01, op_q};
      3'd2:    frame_byte = arg_q[31:24];
      3'd3:    frame_byte = arg_q[23:16];
      3'd4:    frame_byte = arg_q[15:8];
      3'd5:    frame_byte = arg_q[7:0];
      default: frame_byte = {crc_v, 1'b1};
    endcase
  end

  assign xfer_req = (state != S_IDLE);
  assign xfer_tx  = (state == S_SEND) ? frame_byte : 8'hFF;
  assign hs       = xfer_req && xfer_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      idx       <= '0;
      hunt_n    <= '0;
      more_n    <= '0;
      op_q      <= '0;
      arg_q     <= '0;
      kind_q    <= RK_R1;
      cls_q     <= EC_NONE;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_code  <= EC_NONE;
      status_lo <= '0;
      status_hi <= '0;
      resp_word <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            op_q      <= opcode;
            arg_q     <= argument;
            kind_q    <= rkind_t'(resp_kind);
            idx       <= '0;
            busy      <= 1'b1;
            err_code  <= EC_NONE;
            status_lo <= '0;
            status_hi <= '0;
            resp_word <= '0;
            state     <= S_SEND;
          end
        end
        S_SEND: begin
          if (hs) begin
            if (idx == 3'(FRAME_BYTES - 1)) begin
              hunt_n <= '0;
              state  <= S_HUNT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        S_HUNT: begin
          if (hs) begin
            if (xfer_rx == 8'hFF) begin
              if (hunt_n == HW'(NCR_MAX)) begin
                state    <= S_IDLE;
                busy     <= 1'b0;
                done     <= 1'b1;
                err_code <= EC_TIMEOUT;
              end else begin
                hunt_n <= hunt_n + 1'b1;
              end
            end else begin
              status_lo <= xfer_rx;
              cls_q     <= cls_now;
              if (xfer_rx[7]) begin
                state    <= S_IDLE;
                busy     <= 1'b0;
                done     <= 1'b1;
                err_code <= EC_INVAL;
              end else begin
                case (kind_q)
                  RK_R2: begin
                    more_n <= 3'd1;
                    state  <= S_MORE;
                  end
                  RK_R3: begin
                    more_n <= 3'd4;
                    state  <= S_MORE;
                  end
                  RK_R1B: state <= S_BUSY;
                  default: begin
                    state    <= S_IDLE;
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    err_code <= cls_now;
                  end
                endcase
              end
            end
          end
        end
        S_MORE: begin
          if (hs) begin
            if (kind_q == RK_R2)
              status_hi <= xfer_rx;
            else
              resp_word <= {resp_word[23:0], xfer_rx};
            if (more_n == 3'd1) begin
              state    <= S_IDLE;
              busy     <= 1'b0;
              done     <= 1'b1;
              err_code <= cls_q;
            end else begin
              more_n <= more_n - 1'b1;
            end
          end
        end
        S_BUSY: begin
          if (hs && (xfer_rx != 8'h00)) begin
            state    <= S_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            err_code <= cls_q;
          end else if (tmr_exp) begin
            state    <= S_IDLE;
            busy     <= 1'b0;
            done     <= 1'b1;
            err_code <= EC_TIMEOUT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: busy only rises after an accepted start
  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // R3: response phases transmit filler ones
  p_fill_ones_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && (state != S_SEND)) |-> (xfer_tx == 8'hFF));

  // R5: a status byte with its top bit set reports the invalid class
  p_bad_status_r5: assert property (@(posedge clk) disable iff (rst)
    (done && status_lo[7]) |-> (err_code == EC_INVAL));

  // R6: a clean result carries no error bits in the status byte
  p_clean_r6: assert property (@(posedge clk) disable iff (rst)
    (done && (err_code == EC_NONE)) |-> ((status_lo & 8'hFE) == 8'h00));
endmodule

// File: tb/sim_sd_cmd_engine.sv
module sim_sd_cmd_engine;
  localparam int CLK_HZ  = 100_000;
  localparam int BUSY_MS = 10;
  localparam int NCR     = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  opcode = '0;
  logic [31:0] argument = '0;
  logic [1:0]  resp_kind = '0;
  logic        busy, done;
  logic [1:0]  err_code;
  logic [7:0]  status_lo, status_hi;
  logic [31:0] resp_word;
  logic        xfer_req;
  logic [7:0]  xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;

  sd_cmd_engine #(.CLK_HZ(CLK_HZ), .BUSY_MS(BUSY_MS), .NCR_MAX(NCR)) u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .argument(argument),
    .resp_kind(resp_kind), .busy(busy), .done(done), .err_code(err_code),
    .status_lo(status_lo), .status_hi(status_hi), .resp_word(resp_word),
    .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] resp_q[$];
  logic [7:0] fill_b = 8'hFF;
  logic [7:0] exp_frame [7];
  int xn = 0;
  int rp = 0;
  int frame_bad = 0;
  int fill_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  function automatic logic [6:0] ref_crc7(input logic [39:0] m);
    logic [6:0] r = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      if (r[6] ^ m[i]) r = {r[5:0], 1'b0} ^ 7'h09;
      else             r = {r[5:0], 1'b0};
    end
    return r;
  endfunction

  // shifter / card model: answers every request after a varying latency
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_req && !rst) begin
        repeat ((xn % 3) + 1) @(negedge clk);
        if (xfer_req) begin
          if (xn < 7) begin
            if (xfer_tx != exp_frame[xn]) frame_bad++;
            xfer_rx = 8'hFF;
          end else begin
            if (xfer_tx != 8'hFF) fill_bad++;
            xfer_rx = (rp < resp_q.size()) ? resp_q[rp] : fill_b;
            rp++;
          end
          xn++;
          xfer_ack = 1'b1;
          @(negedge clk);
          xfer_ack = 1'b0;
        end
      end
    end
  end

  // behavioural reference for one command outcome
  task automatic model(input int kind, output int e, output logic [7:0] lo,
                       output logic [7:0] hi, output logic [31:0] w, output int nx);
    int p = 0;
    logic [7:0] b;
    int cls;
    bit found = 0;
    lo = 8'h00; hi = 8'h00; w = 32'h0; nx = 0; e = 0;
    for (int k = 0; k <= NCR; k++) begin
      b = (p < resp_q.size()) ? resp_q[p] : fill_b; p++; nx++;
      if (b != 8'hFF) begin found = 1; break; end
    end
    if (!found) begin e = 3; return; end
    lo = b;
    if (b[7]) begin e = 1; return; end
    if (b[6] || b[5] || b[2])      cls = 1;
    else if (b[3] || b[4] || b[1]) cls = 2;
    else                           cls = 0;
    if (kind == 2) begin
      hi = (p < resp_q.size()) ? resp_q[p] : fill_b; p++; nx++;
    end else if (kind == 3) begin
      for (int k = 0; k < 4; k++) begin
        w = {w[23:0], ((p < resp_q.size()) ? resp_q[p] : fill_b)}; p++; nx++;
      end
    end else if (kind == 1) begin
      found = 0;
      while (p < resp_q.size()) begin
        b = resp_q[p]; p++; nx++;
        if (b != 8'h00) begin found = 1; break; end
      end
      if (!found && fill_b == 8'h00) begin e = 3; nx = -1; return; end
      if (!found) nx++;
    end
    e = cls;
  endtask

  task automatic run_cmd(input string tag, input logic [5:0] op,
                         input logic [31:0] arg, input int kind);
    int e, nx, wait_n;
    logic [7:0] lo, hi;
    logic [31:0] w;
    model(kind, e, lo, hi, w, nx);
    exp_frame[0] = 8'hFF;
    exp_frame[1] = {2'b01, op};
    exp_frame[2] = arg[31:24];
    exp_frame[3] = arg[23:16];
    exp_frame[4] = arg[15:8];
    exp_frame[5] = arg[7:0];
    exp_frame[6] = {ref_crc7({2'b01, op, arg}), 1'b1};
    xn = 0; rp = 0; frame_bad = 0; fill_bad = 0;
    @(negedge clk);
    opcode = op; argument = arg; resp_kind = 2'(kind); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R10 busy after start"}, 32'(busy), 32'd1);
    wait_n = 0;
    while (!done && wait_n < 5000) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done == 1'b1, {tag, " R10 done seen"}, 32'(done), 32'd1);
    chk(busy == 1'b0, {tag, " R10 busy low at done"}, 32'(busy), 32'd0);
    chk(frame_bad == 0, {tag, " R1 R2 frame bytes"}, 32'(frame_bad), 32'd0);
    chk(fill_bad == 0, {tag, " R3 filler ones"}, 32'(fill_bad), 32'd0);
    chk(32'(err_code) == 32'(e), {tag, " R4 R5 R6 R9 error code"}, 32'(err_code), 32'(e));
    chk(status_lo == lo, {tag, " R4 status byte"}, 32'(status_lo), 32'(lo));
    chk(status_hi == hi, {tag, " R7 extra byte"}, 32'(status_hi), 32'(hi));
    chk(resp_word == w, {tag, " R8 word"}, resp_word, w);
    if (nx >= 0)
      chk(xn - 7 == nx, {tag, " R5 R11 exchange count"}, 32'(xn - 7), 32'(nx));
    @(negedge clk);
    chk(done == 1'b0, {tag, " R10 done one cycle"}, 32'(done), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0 && xfer_req == 1'b0 && err_code == 2'd0,
        "R11 reset state", {28'd0, done, busy, xfer_req, 1'b0}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // CMD0, R1, known CRC byte
    resp_q = '{8'hFF, 8'h01}; fill_b = 8'hFF;
    run_cmd("cmd0", 6'd0, 32'h0, 0);
    chk(exp_frame[6] == 8'h95, "R2 crc of cmd0", 32'(exp_frame[6]), 32'h95);

    // CMD8, R7 word, known CRC byte
    resp_q = '{8'h01, 8'h00, 8'h00, 8'h01, 8'hAA};
    run_cmd("cmd8", 6'd8, 32'h0000_01AA, 3);
    chk(exp_frame[6] == 8'h87, "R2 crc of cmd8", 32'(exp_frame[6]), 32'h87);

    // R2 second byte
    resp_q = '{8'hFF, 8'hFF, 8'h00, 8'h5A};
    run_cmd("r2", 6'd13, 32'h1234_5678, 2);

    // filler window boundaries
    resp_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00};
    run_cmd("ncr_max", 6'd63, 32'hFFFF_FFFF, 0);
    resp_q = '{};
    run_cmd("ncr_timeout", 6'd17, 32'hA5A5_0F0F, 0);

    // invalid response stops immediately
    resp_q = '{8'hC1, 8'h00, 8'h00};
    run_cmd("bit7", 6'd55, 32'h0, 3);

    // classification and priority
    resp_q = '{8'h04}; run_cmd("illegal", 6'd5, 32'h1, 0);
    resp_q = '{8'h48}; run_cmd("param_over_crc", 6'd6, 32'h2, 0);
    resp_q = '{8'h08}; run_cmd("com_crc", 6'd7, 32'h3, 0);
    resp_q = '{8'h10}; run_cmd("erase_seq", 6'd9, 32'h4, 0);
    resp_q = '{8'h02}; run_cmd("erase_reset", 6'd10, 32'h5, 0);
    resp_q = '{8'h08, 8'hDE, 8'hAD, 8'hBE, 8'hEF};
    run_cmd("crc_with_word", 6'd58, 32'h0, 3);

    // busy phase ends, then busy phase times out
    resp_q = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF};
    run_cmd("r1b_end", 6'd12, 32'h0, 1);
    resp_q = '{8'h00}; fill_b = 8'h00;
    run_cmd("r1b_timeout", 6'd38, 32'h0, 1);
    fill_b = 8'hFF;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule